// File: doc/BRIEF.md
# Master Clock Source Switch Controller

This block picks where the output master clock comes from: the clock recovered by a PLL or a clock derived from a crystal oscillator. Both sources arrive as edge strobes in the system clock domain. Each source path has its own divider. The chosen path feeds a post-divider that toggles a registered master clock level. The block also drives the enable of the oscillator amplifier. It hands the output over from one source to the other only while the output clock is low, so no high pulse is ever shortened.

A sample-rate meter counts incoming frame strobes over a fixed window of reference ticks. It raises a receive error when successive counts disagree. Starting a stopped amplifier restarts this measurement. Restarting discards the accepted count, so the error flag goes high until two new windows agree. Software can avoid this error in two ways: keep the amplifier running all the time, or mask rate changes from the flag. When the PLL loses lock, the block moves to the crystal path by itself. It returns to the PLL path once lock comes back.

Top module: `mcs_clock_switch`

## Requirements
- R1: While reset is held and on the first cycle after it, amp_en, active_xtal, mclk_out and rx_err are all low.
- R2: amp_en is registered one cycle after its inputs. It is high when cfg_amp_mode is not 00, when cfg_src_xtal is 1, or when pll_locked is 0. With code 00, PLL source requested and lock present, it is low.
- R3: The meter counts frame_strobe over windows of WIN_TICKS ref_tick pulses. rx_err rises after a window whose count differs from the previous window. It falls after two consecutive windows give equal counts.
- R4: When amp_en rises (stopped amplifier started), the measurement restarts and rx_err is high on the following cycle. rx_err stays high until two later windows agree.
- R5: With cfg_amp_mode not 00 (01 = run continuously, 10/11 treated alike), a change of cfg_src_xtal leaves rx_err unchanged.
- R6: With cfg_rate_mask = 1, rx_err is low from the next cycle on, whatever the rate does.
- R7: A switch to the crystal path waits while osc_ready is low. active_xtal (1 = crystal, 0 = PLL) rises only after osc_ready has been high, and the old source keeps driving mclk_out until then.
- R8: With lock present, a switch back to the PLL path happens on the first cycle in which mclk_out is low.
- R9: When pll_locked falls, the block moves to the crystal path without any register change. When lock returns with cfg_src_xtal = 0, it goes back to the PLL path.
- R10: active_xtal changes only while mclk_out is low, and mclk_out holds its level in that cycle. Every high phase therefore comes from one source.
- R11: Divider codes: cfg_xdiv 0 gives N=1 and 1 gives N=2. cfg_pdiv and cfg_odiv give 00→1, 01→2, 10→4, 11→4. The mclk_out period is 2·M·N source ticks, where M comes from cfg_odiv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_tick | input | 1 | Edge strobe of the recovered PLL clock |
| xtal_tick | input | 1 | Edge strobe of the crystal clock |
| pll_locked | input | 1 | PLL lock level |
| osc_ready | input | 1 | Synchronized oscillator-started level |
| ref_tick | input | 1 | Reference tick for the rate window |
| frame_strobe | input | 1 | One pulse per received frame |
| cfg_src_xtal | input | 1 | Requested source, 1 = crystal |
| cfg_amp_mode | input | 2 | Amplifier mode, 00 = stop when idle |
| cfg_rate_mask | input | 1 | 1 = rate changes not reported |
| cfg_xdiv | input | 1 | Crystal path divider code |
| cfg_pdiv | input | 2 | PLL path divider code |
| cfg_odiv | input | 2 | Output post-divider code |
| amp_en | output | 1 | Oscillator amplifier enable |
| active_xtal | output | 1 | Source now driving the output, 1 = crystal |
| mclk_out | output | 1 | Divided master clock level |
| rx_err | output | 1 | Receive rate error flag |

## Verification
The frame rate is first held steady, then stepped up. This separates the clearing rule (two equal windows) from the setting rule (one differing window). Source switches are tried with a stopped amplifier and with a running one, and with the mask set and clear. These show that only a real amplifier start disturbs the flag. Holding osc_ready low during a crystal request separates a pending switch from a finished one, and a lock loss shows that the switch happens without any register write. A sweep over every divider code on both paths measures the output period, which confirms each N and M factor on its own.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int RATIO_W = 3;

  function automatic logic [RATIO_W-1:0] ratio_124(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_12(input logic code);
    return code ? 3'd2 : 3'd1;
  endfunction
endpackage

// File: rtl/mcs_path_div.sv
module mcs_path_div
  import mcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               ev
);
  logic [RATIO_W-1:0] cnt;
  logic               last;

  assign last = (cnt >= ratio - 3'd1);
  assign ev   = tick && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= last ? '0 : cnt + 3'd1;
    end
  end
endmodule

// File: rtl/mcs_out_clk.sv
module mcs_out_clk
  import mcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_pll,
  input  logic               ev_xtal,
  input  logic               target_xtal,
  input  logic               xtal_ok,
  input  logic [RATIO_W-1:0] ratio,
  output logic               active_xtal,
  output logic               mclk
);
  logic [RATIO_W-1:0] cnt;
  logic               sel_ev;
  logic               may_go;
  logic               do_switch;

  assign sel_ev    = active_xtal ? ev_xtal : ev_pll;
  assign may_go    = target_xtal ? xtal_ok : 1'b1;
  assign do_switch = (target_xtal != active_xtal) && may_go && !mclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_xtal <= 1'b0;
      mclk        <= 1'b0;
      cnt         <= '0;
    end else if (do_switch) begin
      active_xtal <= target_xtal;
      cnt         <= '0;
    end else if (sel_ev) begin
      if (cnt >= ratio - 3'd1) begin
        cnt  <= '0;
        mclk <= !mclk;
      end else begin
        cnt <= cnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/mcs_rate_meter.sv
module mcs_rate_meter #(
  parameter int WIN_TICKS = 256,
  parameter int CNT_W     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic ref_tick,
  input  logic frame_strobe,
  output logic err
);
  localparam int WIN_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;

  logic [WIN_W-1:0] wcnt;
  logic [CNT_W-1:0] fcnt;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] cur;
  logic             last_valid;
  logic             win_end;

  assign win_end = ref_tick && (wcnt == WIN_W'(WIN_TICKS - 1));
  assign cur     = fcnt + CNT_W'(frame_strobe);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      wcnt       <= '0;
      fcnt       <= '0;
      last_cnt   <= '0;
      last_valid <= 1'b0;
      err        <= 1'b1;
    end else begin
      if (ref_tick) begin
        wcnt <= win_end ? '0 : wcnt + 1'b1;
      end
      if (win_end) begin
        fcnt       <= '0;
        last_cnt   <= cur;
        last_valid <= 1'b1;
        err        <= !(last_valid && (cur == last_cnt));
      end else begin
        fcnt <= cur;
      end
    end
  end
endmodule

// File: rtl/mcs_clock_switch.sv
module mcs_clock_switch
  import mcs_pkg::*;
#(
  parameter int WIN_TICKS = 256,
  parameter int CNT_W     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_tick,
  input  logic       xtal_tick,
  input  logic       pll_locked,
  input  logic       osc_ready,
  input  logic       ref_tick,
  input  logic       frame_strobe,
  input  logic       cfg_src_xtal,
  input  logic [1:0] cfg_amp_mode,
  input  logic       cfg_rate_mask,
  input  logic       cfg_xdiv,
  input  logic [1:0] cfg_pdiv,
  input  logic [1:0] cfg_odiv,
  output logic       amp_en,
  output logic       active_xtal,
  output logic       mclk_out,
  output logic       rx_err
);
  localparam int NSRC = 2;

  logic             target_xtal;
  logic             amp_want;
  logic             restart;
  logic             meas_err;
  logic [NSRC-1:0]  src_tick;
  logic [NSRC-1:0]  src_ev;
  logic [RATIO_W-1:0] src_ratio [NSRC];

  assign target_xtal  = cfg_src_xtal || !pll_locked;
  assign amp_want     = (cfg_amp_mode != 2'b00) || target_xtal;
  assign restart      = amp_want && !amp_en;
  assign src_tick     = {xtal_tick, pll_tick};
  assign src_ratio[0] = ratio_124(cfg_pdiv);
  assign src_ratio[1] = ratio_12(cfg_xdiv);

  for (genvar s = 0; s < NSRC; s++) begin : g_path
    mcs_path_div u_div (
      .clk   (clk),
      .rst   (rst),
      .tick  (src_tick[s]),
      .ratio (src_ratio[s]),
      .ev    (src_ev[s])
    );
  end

  mcs_out_clk u_out (
    .clk         (clk),
    .rst         (rst),
    .ev_pll      (src_ev[0]),
    .ev_xtal     (src_ev[1]),
    .target_xtal (target_xtal),
    .xtal_ok     (osc_ready && amp_en),
    .ratio       (ratio_124(cfg_odiv)),
    .active_xtal (active_xtal),
    .mclk        (mclk_out)
  );

  mcs_rate_meter #(.WIN_TICKS(WIN_TICKS), .CNT_W(CNT_W)) u_meter (
    .clk          (clk),
    .rst          (rst),
    .restart      (restart),
    .ref_tick     (ref_tick),
    .frame_strobe (frame_strobe),
    .err          (meas_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_en <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      amp_en <= amp_want;
      rx_err <= meas_err && !cfg_rate_mask;
    end
  end
endmodule

// File: rtl/mcs_clock_switch_chk.sv
module mcs_clock_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic       osc_ready,
  input logic [1:0] cfg_amp_mode,
  input logic       cfg_rate_mask,
  input logic       amp_en,
  input logic       active_xtal,
  input logic       mclk_out,
  input logic       rx_err
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_switch_low_R10: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (active_xtal != $past(active_xtal)) |-> (!$past(mclk_out) && !mclk_out));

  assert_xtal_after_ready_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $rose(active_xtal) |-> $past(osc_ready));

  assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_rate_mask |=> !rx_err);

  assert_amp_continuous_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_amp_mode != 2'b00) |=> amp_en);

  assert_start_flags_err_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($rose(amp_en) && !cfg_rate_mask) |=> rx_err);
endmodule

bind mcs_clock_switch mcs_clock_switch_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .osc_ready     (osc_ready),
  .cfg_amp_mode  (cfg_amp_mode),
  .cfg_rate_mask (cfg_rate_mask),
  .amp_en        (amp_en),
  .active_xtal   (active_xtal),
  .mclk_out      (mclk_out),
  .rx_err        (rx_err)
);

// File: tb/test_mcs_clock_switch.sv
module test_mcs_clock_switch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_tick = 1'b0, xtal_tick = 1'b0, ref_tick = 1'b0, frame_strobe = 1'b0;
  logic pll_locked = 1'b1, osc_ready = 1'b0;
  logic cfg_src_xtal = 1'b0, cfg_rate_mask = 1'b0, cfg_xdiv = 1'b0;
  logic [1:0] cfg_amp_mode = 2'b00, cfg_pdiv = 2'b00, cfg_odiv = 2'b01;
  logic amp_en, active_xtal, mclk_out, rx_err;

  int checks = 0, errors = 0;
  int cyc = 0, fper = 4;
  int hlen = 0, min_high = 1000;

  always #4 clk = !clk;

  mcs_clock_switch #(.WIN_TICKS(4), .CNT_W(8)) i_mcs_clock_switch (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
    .pll_locked(pll_locked), .osc_ready(osc_ready), .ref_tick(ref_tick),
    .frame_strobe(frame_strobe), .cfg_src_xtal(cfg_src_xtal),
    .cfg_amp_mode(cfg_amp_mode), .cfg_rate_mask(cfg_rate_mask),
    .cfg_xdiv(cfg_xdiv), .cfg_pdiv(cfg_pdiv), .cfg_odiv(cfg_odiv),
    .amp_en(amp_en), .active_xtal(active_xtal), .mclk_out(mclk_out), .rx_err(rx_err)
  );

  // stimulus strobes, changed away from the active edge
  initial forever begin
    @(negedge clk);
    cyc++;
    pll_tick     = 1'b1;
    xtal_tick    = (cyc % 3 == 0);
    ref_tick     = cyc[0];
    frame_strobe = (cyc % fper == 0);
  end

  // high-phase length monitor
  initial forever begin
    @(negedge clk);
    if (mclk_out) hlen++;
    else begin
      if (hlen > 0 && hlen < min_high) min_high = hlen;
      hlen = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int r124(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  task automatic period(output int p);
    bit prev;
    int guard;
    p = 0;
    guard = 0;
    prev = mclk_out;
    while (!(mclk_out && !prev) && guard < 500) begin
      prev = mclk_out; step(1); guard++;
    end
    prev = mclk_out;
    step(1); p = 1;
    while (!(mclk_out && !prev) && p < 500) begin
      prev = mclk_out; step(1); p++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad, p;
    step(4);
    // R1 reset state
    chk(!amp_en, "R1 amp_en", amp_en, 0);
    chk(!active_xtal, "R1 active_xtal", active_xtal, 0);
    chk(!mclk_out && !rx_err, "R1 mclk/rx_err", {mclk_out, rx_err}, 0);
    rst = 1'b0;
    step(60);
    chk(rx_err == 0, "R3 steady rate clears", rx_err, 0);
    chk(amp_en == 0, "R2 stopped when idle", amp_en, 0);
    // R3 rate step
    fper = 2;
    step(13);
    chk(rx_err == 1, "R3 rate change flagged", rx_err, 1);
    step(50);
    chk(rx_err == 0, "R3 two equal windows clear", rx_err, 0);
    // R6 mask
    cfg_rate_mask = 1'b1;
    fper = 4;
    step(1);
    bad = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (rx_err) bad++; end
    chk(bad == 0, "R6 masked flag", bad, 0);
    step(40);
    cfg_rate_mask = 1'b0;
    step(3);
    chk(rx_err == 0, "R6 unmasked settled", rx_err, 0);
    // R7 / R4 switch with stopped amplifier
    min_high = 1000;
    cfg_src_xtal = 1'b1;
    step(3);
    chk(amp_en == 1, "R2 amp on for crystal", amp_en, 1);
    chk(rx_err == 1, "R4 restart flags error", rx_err, 1);
    step(30);
    chk(active_xtal == 0, "R7 pending while not ready", active_xtal, 0);
    osc_ready = 1'b1;
    step(20);
    chk(active_xtal == 1, "R7 crystal after ready", active_xtal, 1);
    step(60);
    chk(rx_err == 0, "R4 error clears", rx_err, 0);
    // R8 back to PLL
    cfg_src_xtal = 1'b0;
    step(8);
    chk(active_xtal == 0, "R8 PLL within one high phase", active_xtal, 0);
    osc_ready = 1'b0;
    step(30);
    chk(amp_en == 0, "R2 amp stops", amp_en, 0);
    chk(rx_err == 0, "R4 stop does not restart", rx_err, 0);
    chk(min_high >= 2, "R10 no runt high phase", min_high, 2);
    // R5 continuous amplifier
    cfg_amp_mode = 2'b01;
    osc_ready = 1'b1;
    step(60);
    cfg_src_xtal = 1'b1;
    bad = 0;
    for (int i = 0; i < 50; i++) begin step(1); if (rx_err) bad++; end
    chk(bad == 0, "R5 switch keeps flag", bad, 0);
    chk(active_xtal == 1, "R5 crystal reached", active_xtal, 1);
    cfg_src_xtal = 1'b0;
    step(20);
    // R9 lock loss
    pll_locked = 1'b0;
    step(20);
    chk(active_xtal == 1, "R9 unlock to crystal", active_xtal, 1);
    pll_locked = 1'b1;
    step(20);
    chk(active_xtal == 0, "R9 relock to PLL", active_xtal, 0);
    // R11 divider sweep, PLL path (tick every cycle)
    for (int pd = 0; pd < 4; pd++) begin
      for (int od = 0; od < 4; od++) begin
        cfg_pdiv = 2'(pd); cfg_odiv = 2'(od);
        step(60);
        period(p);
        chk(p == 2 * r124(pd) * r124(od), "R11 PLL period", p, 2 * r124(pd) * r124(od));
      end
    end
    // R11 crystal path (tick every third cycle)
    cfg_src_xtal = 1'b1;
    for (int xd = 0; xd < 2; xd++) begin
      for (int od = 0; od < 4; od++) begin
        cfg_xdiv = 1'(xd); cfg_odiv = 2'(od);
        step(60);
        period(p);
        chk(p == 6 * (xd + 1) * r124(od), "R11 crystal period", p, 6 * (xd + 1) * r124(od));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule